// File: doc/BRIEF.md
# Isochronous Split-Transaction Sequencer

This block is the control sequencer a high-speed USB host runs once per isochronous split descriptor. The descriptor moves data with a full-speed device that sits behind a hub. The periodic schedule walker hands the block one descriptor per handshake. The descriptor carries:

- an Active flag and a direction;
- the current sequencer state;
- a start-split schedule mask and a complete-split schedule mask;
- a complete-split progress mask;
- the one-hot bit of the current micro-frame;
- the response to the complete-split in this micro-frame;
- a flag that marks a frame scheduling boundary.

One cycle later the block reports which split transaction to issue, if any. It also returns the updated Active flag, state and progress mask, and strobes for a buffer advance or a missed complete-split.

Mask bit i stands for micro-frame i, with bit 0 the earliest. Start-splits run in the start-split state. Only IN descriptors go on to the complete-split state. An OUT descriptor stays in the start-split state for its whole life. A complete-split is allowed only when the previous scheduled complete-split in the mask shows as done in the progress mask.

Top module: `isplit_seq`

## Requirements
- R1: When Active is 0 the block returns skip=1 and issues no split. Active, state and the progress mask come back unchanged.
- R2: In the start-split state (state=0) a start-split is issued only when the start-split mask ANDed with the micro-frame bit is nonzero. When no start-split is issued, the state, Active and the progress mask are unchanged.
- R3: An OUT descriptor (dirIn=0) never leaves state 0. Its start-split in the highest set start-split mask bit clears Active.
- R4: An IN start-split moves the state to complete-split (state=1) and clears the progress mask.
- R5: In state 1 a complete-split is issued only when two things hold. First, the complete-split mask ANDed with the micro-frame bit is nonzero. Second, the previous-bit check passes: either no lower complete-split mask bit is set, or the progress bit at the nearest lower set mask bit is 1. Each issued complete-split sets the progress bit of the current micro-frame.
- R6: A failed previous-bit check issues nothing, clears Active and raises err.
- R7: The response is coded 00 DONE, 01 MDATA, 10 NYET. MDATA raises advance and keeps state 1. NYET keeps state 1 unless it arrives on the highest set complete-split mask bit; there it clears Active and raises err.
- R8: A DONE response returns the state to 0 with Active kept at 1 when the boundary flag is 1. Otherwise it clears Active.
- R9: Results appear with outValid exactly one cycle after an accepted handshake (inValid and inReady). After reset, outValid is 0 and inReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Descriptor presented |
| inReady | output | 1 | Block accepts a descriptor |
| inActive | input | 1 | Active flag of the descriptor |
| inDirIn | input | 1 | 1 = IN, 0 = OUT |
| inState | input | 1 | 0 = start-split, 1 = complete-split |
| inSMask | input | NUF | Start-split micro-frame mask |
| inCMask | input | NUF | Complete-split micro-frame mask |
| inCProg | input | NUF | Complete-split progress mask |
| inUFrame | input | NUF | One-hot current micro-frame |
| inResp | input | 2 | Complete-split response code |
| inBoundary | input | 1 | Frame scheduling boundary case |
| outValid | output | 1 | Result valid |
| outActive | output | 1 | Updated Active flag |
| outState | output | 1 | Updated state |
| outCProg | output | NUF | Updated progress mask |
| outIssueSs | output | 1 | Issue a start-split |
| outIssueCs | output | 1 | Issue a complete-split |
| outAdvance | output | 1 | Advance buffer state |
| outErr | output | 1 | Missed complete-split or final NYET |
| outSkip | output | 1 | Inactive descriptor, walker moves on |

## Verification
Every result field is registered once, so every result is due one clock edge after the edge that accepts the descriptor. The bench drives each descriptor on a falling edge. At the next falling edge it compares the full result word against a model computed from the requirements, and then drives the next descriptor. Each accepted descriptor therefore produces one comparison, made half a cycle after the result registers update. The idle check after the sweep confirms that outValid drops one cycle after inValid falls.

// File: rtl/isplit_pkg.sv
package isplit_pkg;
  typedef enum logic {
    ST_START    = 1'b0,
    ST_COMPLETE = 1'b1
  } splitState_t;

  typedef enum logic [1:0] {
    RSP_DONE  = 2'b00,
    RSP_MDATA = 2'b01,
    RSP_NYET  = 2'b10
  } csResp_t;

  typedef struct packed {
    logic issueSs;
    logic issueCs;
    logic gotoComplete;
    logic gotoStart;
    logic clearActive;
    logic flagErr;
    logic advance;
    logic skip;
  } seqStrobe_t;
endpackage

// File: rtl/isplit_ctrl.sv
module isplit_ctrl
  import isplit_pkg::*;
(
  input  logic       fire,
  input  logic       active,
  input  logic       dirIn,
  input  logic       state,
  input  logic       ssHit,
  input  logic       lastSs,
  input  logic       csHit,
  input  logic       prevOk,
  input  logic       lastCs,
  input  logic [1:0] resp,
  input  logic       boundary,
  output seqStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (fire) begin
      if (!active) begin
        strobe.skip = 1'b1;
      end else if (state == ST_START) begin
        if (ssHit) begin
          strobe.issueSs = 1'b1;
          if (dirIn) strobe.gotoComplete = 1'b1;
          else if (lastSs) strobe.clearActive = 1'b1;
        end
      end else if (csHit) begin
        if (!prevOk) begin
          strobe.clearActive = 1'b1;
          strobe.flagErr     = 1'b1;
        end else begin
          strobe.issueCs = 1'b1;
          case (resp)
            RSP_MDATA: strobe.advance = 1'b1;
            RSP_NYET: begin
              if (lastCs) begin
                strobe.clearActive = 1'b1;
                strobe.flagErr     = 1'b1;
              end
            end
            RSP_DONE: begin
              if (boundary) strobe.gotoStart = 1'b1;
              else strobe.clearActive = 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/isplit_dp.sv
module isplit_dp
  import isplit_pkg::*;
#(
  parameter int NUF = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           fire,
  input  logic           active,
  input  logic           state,
  input  logic [NUF-1:0] sMask,
  input  logic [NUF-1:0] cMask,
  input  logic [NUF-1:0] cProg,
  input  logic [NUF-1:0] uFrame,
  input  seqStrobe_t     strobe,
  output logic           ssHit,
  output logic           lastSs,
  output logic           csHit,
  output logic           prevOk,
  output logic           lastCs,
  output logic           readyQ,
  output logic           outValid,
  output logic           outActive,
  output logic           outState,
  output logic [NUF-1:0] outCProg,
  output logic           outIssueSs,
  output logic           outIssueCs,
  output logic           outAdvance,
  output logic           outErr,
  output logic           outSkip
);
  localparam logic [NUF-1:0] ONE = NUF'(1);

  function automatic logic [NUF-1:0] topBit(input logic [NUF-1:0] v);
    logic [NUF-1:0] r;
    r = '0;
    for (int i = 0; i < NUF; i++) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  logic [NUF-1:0] belowMask, aboveMask, lowerCs, nearCs, nextProg;

  always_comb begin
    belowMask = uFrame - ONE;
    aboveMask = ~(uFrame | belowMask);
    ssHit     = |(sMask & uFrame);
    csHit     = |(cMask & uFrame);
    lastSs    = ~|(sMask & aboveMask);
    lastCs    = ~|(cMask & aboveMask);
    lowerCs   = cMask & belowMask;
    nearCs    = topBit(lowerCs);
    prevOk    = (lowerCs == '0) || (|(cProg & nearCs));
    if (strobe.gotoComplete)  nextProg = '0;
    else if (strobe.issueCs)  nextProg = cProg | uFrame;
    else                      nextProg = cProg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ     <= 1'b0;
      outValid   <= 1'b0;
      outActive  <= 1'b0;
      outState   <= 1'b0;
      outCProg   <= '0;
      outIssueSs <= 1'b0;
      outIssueCs <= 1'b0;
      outAdvance <= 1'b0;
      outErr     <= 1'b0;
      outSkip    <= 1'b0;
    end else begin
      readyQ     <= 1'b1;
      outValid   <= fire;
      outIssueSs <= strobe.issueSs;
      outIssueCs <= strobe.issueCs;
      outAdvance <= strobe.advance;
      outErr     <= strobe.flagErr;
      outSkip    <= strobe.skip;
      if (fire) begin
        outActive <= active & ~strobe.clearActive;
        outState  <= strobe.gotoComplete ? ST_COMPLETE :
                     strobe.gotoStart    ? ST_START    : state;
        outCProg  <= nextProg;
      end
    end
  end
endmodule

// File: rtl/isplit_seq.sv
module isplit_seq
  import isplit_pkg::*;
#(
  parameter int NUF = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  output logic           inReady,
  input  logic           inActive,
  input  logic           inDirIn,
  input  logic           inState,
  input  logic [NUF-1:0] inSMask,
  input  logic [NUF-1:0] inCMask,
  input  logic [NUF-1:0] inCProg,
  input  logic [NUF-1:0] inUFrame,
  input  logic [1:0]     inResp,
  input  logic           inBoundary,
  output logic           outValid,
  output logic           outActive,
  output logic           outState,
  output logic [NUF-1:0] outCProg,
  output logic           outIssueSs,
  output logic           outIssueCs,
  output logic           outAdvance,
  output logic           outErr,
  output logic           outSkip
);
  seqStrobe_t strobe;
  logic fire, ssHit, lastSs, csHit, prevOk, lastCs;

  assign fire = inValid & inReady;

  isplit_ctrl uCtrl (
    .fire(fire), .active(inActive), .dirIn(inDirIn), .state(inState),
    .ssHit(ssHit), .lastSs(lastSs), .csHit(csHit), .prevOk(prevOk),
    .lastCs(lastCs), .resp(inResp), .boundary(inBoundary), .strobe(strobe)
  );

  isplit_dp #(.NUF(NUF)) uDp (
    .clk(clk), .rstN(rstN), .fire(fire), .active(inActive), .state(inState),
    .sMask(inSMask), .cMask(inCMask), .cProg(inCProg), .uFrame(inUFrame),
    .strobe(strobe), .ssHit(ssHit), .lastSs(lastSs), .csHit(csHit),
    .prevOk(prevOk), .lastCs(lastCs), .readyQ(inReady), .outValid(outValid),
    .outActive(outActive), .outState(outState), .outCProg(outCProg),
    .outIssueSs(outIssueSs), .outIssueCs(outIssueCs),
    .outAdvance(outAdvance), .outErr(outErr), .outSkip(outSkip)
  );
endmodule

// File: rtl/isplit_chk.sv
module isplit_chk #(
  parameter int NUF = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           inReady,
  input logic           inActive,
  input logic           inDirIn,
  input logic           inState,
  input logic [NUF-1:0] inCProg,
  input logic [NUF-1:0] inUFrame,
  input logic           outValid,
  input logic           outActive,
  input logic           outState,
  input logic [NUF-1:0] outCProg,
  input logic           outIssueSs,
  input logic           outIssueCs,
  input logic           outErr,
  input logic           outSkip
);
  AST_ONE_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    !(outIssueSs && outIssueCs)); // R2
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outSkip |-> !outIssueSs && !outIssueCs && !outActive); // R1
  AST_OUT_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && inActive && !inDirIn && !inState |=> outState == 1'b0); // R3
  AST_IN_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outIssueSs && outState |-> outCProg == '0); // R4
  AST_CS_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && inActive && inState |=> !outIssueCs || ((outCProg & $past(inUFrame)) != '0)); // R5
  AST_ERR_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outErr |-> !outActive); // R6
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> !outValid); // R9
  AST_PROG_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && !inActive |=> outCProg == $past(inCProg)); // R1
endmodule

bind isplit_seq isplit_chk #(.NUF(NUF)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inActive(inActive), .inDirIn(inDirIn), .inState(inState),
  .inCProg(inCProg), .inUFrame(inUFrame), .outValid(outValid),
  .outActive(outActive), .outState(outState), .outCProg(outCProg),
  .outIssueSs(outIssueSs), .outIssueCs(outIssueCs), .outErr(outErr),
  .outSkip(outSkip)
);

// File: tb/sim_isplit_seq.sv
`timescale 1ns/1ps
module sim_isplit_seq;
  localparam int NUF = 8;
  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic inActive = 1'b0, inDirIn = 1'b0, inState = 1'b0, inBoundary = 1'b0;
  logic [NUF-1:0] inSMask = '0, inCMask = '0, inCProg = '0, inUFrame = 8'h01;
  logic [1:0] inResp = 2'b00;
  logic outValid, outActive, outState, outIssueSs, outIssueCs;
  logic outAdvance, outErr, outSkip;
  logic [NUF-1:0] outCProg;
  int nChecks = 0, nFails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  isplit_seq #(.NUF(NUF)) u0 (.*);

  // result word: {valid, active, state, prog, ss, cs, adv, err, skip}
  logic [15:0] expWord;
  string expTag;

  task automatic model(input logic a, input logic d, input logic st,
                       input logic [7:0] s, input logic [7:0] c,
                       input logic [7:0] p, input logic [7:0] uf,
                       input logic [1:0] rsp, input logic bnd);
    logic na, nst, ss, cs, adv, er, sk, ok, higher;
    logic [7:0] np;
    int idx, near;
    na = a; nst = st; np = p; ss = 0; cs = 0; adv = 0; er = 0; sk = 0;
    idx = 0;
    for (int i = 0; i < 8; i++) if (uf[i]) idx = i;
    expTag = "R2";
    if (!a) begin
      sk = 1; expTag = "R1";
    end else if (!st) begin
      if ((s & uf) != 0) begin
        ss = 1;
        if (d) begin
          nst = 1; np = 0; expTag = "R4";
        end else begin
          higher = 0;
          for (int i = idx + 1; i < 8; i++) if (s[i]) higher = 1;
          if (!higher) na = 0;
          expTag = "R3";
        end
      end
    end else if ((c & uf) != 0) begin
      near = -1;
      for (int i = 0; i < idx; i++) if (c[i]) near = i;
      ok = (near < 0) ? 1'b1 : p[near];
      if (!ok) begin
        na = 0; er = 1; expTag = "R6";
      end else begin
        cs = 1; np = p | uf; expTag = "R5";
        higher = 0;
        for (int i = idx + 1; i < 8; i++) if (c[i]) higher = 1;
        if (rsp == 2'b01) begin
          adv = 1; expTag = "R7";
        end else if (rsp == 2'b10) begin
          expTag = "R7";
          if (!higher) begin na = 0; er = 1; end
        end else begin
          expTag = "R8";
          if (bnd) nst = 0; else na = 0;
        end
      end
    end else expTag = "R5";
    expWord = {1'b1, na, nst, np, ss, cs, adv, er, sk};
  endtask

  task automatic applyVec(input logic a, input logic d, input logic st,
                          input logic [7:0] s, input logic [7:0] c,
                          input logic [7:0] p, input logic [7:0] uf,
                          input logic [1:0] rsp, input logic bnd);
    logic [15:0] got;
    inValid = 1; inActive = a; inDirIn = d; inState = st; inSMask = s;
    inCMask = c; inCProg = p; inUFrame = uf; inResp = rsp; inBoundary = bnd;
    model(a, d, st, s, c, p, uf, rsp, bnd);
    @(negedge clk);  // registered result is due after one rising edge (R9)
    got = {outValid, outActive, outState, outCProg, outIssueSs, outIssueCs,
           outAdvance, outErr, outSkip};
    nChecks++;
    if (got !== expWord) begin
      nFails++;
      $display("FAIL %s got %h expected %h (a=%b d=%b st=%b s=%h c=%h p=%h uf=%h rsp=%0d b=%b)",
               expTag, got, expWord, a, d, st, s, c, p, uf, rsp, bnd);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || inReady !== 1'b0) begin
      nFails++;
      $display("FAIL R9 reset got valid=%b ready=%b expected 0 0", outValid, inReady);
    end
    rstN = 1'b1;
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      nFails++;
      $display("FAIL R9 after reset got valid=%b ready=%b expected 0 1", outValid, inReady);
    end
    // R1: inactive descriptors in both states
    for (int st = 0; st < 2; st++)
      for (int u = 0; u < 8; u++)
        applyVec(0, 1, st[0], 8'hFF, 8'hFF, 8'h5A, 8'(1 << u), 2'b00, 1);
    // R2 R3 R4: start-split state sweep over mask, micro-frame, direction
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 256; s++)
        for (int u = 0; u < 8; u++)
          applyVec(1, d[0], 0, 8'(s), 8'h3C, 8'hA5, 8'(1 << u), 2'b00, 0);
    // R5 R6 R7 R8: complete-split state sweep
    for (int pi = 0; pi < 4; pi++)
      for (int c = 0; c < 256; c++)
        for (int u = 0; u < 8; u++)
          for (int r = 0; r < 3; r++)
            for (int b = 0; b < 2; b++) begin
              logic [7:0] pv;
              pv = (pi == 0) ? 8'h00 : (pi == 1) ? 8'hFF : (pi == 2) ? 8'h55 : 8'hAA;
              applyVec(1, 1, 1, 8'h01, 8'(c), pv, 8'(1 << u), 2'(r), b[0]);
            end
    // R9: no result without a handshake
    inValid = 0;
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0) begin
      nFails++;
      $display("FAIL R9 idle got valid=%b expected 0", outValid);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule